// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter inside a microcontroller peripheral. Software programs a control/status byte that holds the input channel, the start command, an external-start enable, a completion flag and the two least significant result bits. A second, read-only byte holds the eight upper result bits. The block drives the trial code to an external DAC and reads back one comparator decision bit. It also drives the select lines of an eight-way analog input multiplexer.

A one-clock `mc_tick` pulse marks each machine-cycle boundary, and all conversion timing is counted in these ticks. A conversion can start in two ways. Software writes the start bit. Or, when external start is enabled, the start pin shows a low-to-high change between two tick boundaries. Each conversion spends two machine cycles in initialisation and eight in sampling, then four on each of the ten bit trials, from the most significant bit down. Raising `low_power` stops a conversion that is under way and leaves any finished result in place.

Top module: `sar_seq`

## Requirements
- R1: When control bit 5 (external enable) is 0, no transition on `ext_start` begins a conversion. Control bit 3 (busy) stays 0.
- R2: When control bit 5 is 1, a conversion begins at a tick boundary where the synchronised pin is seen high and the previous boundary saw it low. Busy reads 1 after the next tick, and `done_flag` rises on the 51st tick counted from the starting boundary.
- R3: Writing 1 to control bit 3 while idle begins a conversion at the next tick boundary. `done_flag` is still 0 after the 50th tick following the write and is 1 after the 51st.
- R4: Control bit 3 reads as the busy status, not the command. It is 0 after the write and after the first following tick. It is 1 from the second tick until completion, and 0 again after completion.
- R5: `dac_word` is 0 while idle. It becomes 10'h200 at the starting boundary and holds that value through 2 initialisation, 8 sampling and the first 4 trial ticks.
- R6: At the end of each 4-tick trial, the tested bit stays 1 only if `cmp_gt` is 1, and the next lower bit is set for the next trial. With an input code v, this yields a final code of v-1 (0 for v=0).
- R7: On completion, `high_rd` holds result bits 9..2, control bits 7..6 hold result bits 1..0, and the done flag (control bit 4 and `done_flag`) becomes 1 while busy becomes 0.
- R8: `mux_sel` equals control bits 2..0, as last written.
- R9: A software or external start request that arrives during a conversion has no effect. The running conversion ends on its original schedule, and no second conversion follows.
- R10: Raising `low_power` ends a running conversion at once. Busy goes to 0 and `dac_word` to 0, while the done flag and the stored result stay unchanged. Start writes made while `low_power` is high are dropped.
- R11: Writing 0 to control bit 4 clears the done flag. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-clock pulse at each machine-cycle boundary |
| low_power | input | 1 | Idle/power-down entry; aborts a conversion |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 6 | Written bits 5..0: ext enable, done clear, start, channel |
| ctrl_rd | output | 8 | Control/status byte: {res[1:0], ext_en, done, busy, channel} |
| high_rd | output | 8 | Upper eight result bits |
| ext_start | input | 1 | Asynchronous external start pin |
| cmp_gt | input | 1 | Comparator: 1 when analog input exceeds DAC output |
| dac_word | output | 10 | Trial code driven to the DAC |
| mux_sel | output | 3 | Analog channel select |
| done_flag | output | 1 | Level copy of the done flag |

## Verification
The hardest case to reach is an abort that lands partway through the bit trials while an earlier, unconsumed result is still marked done. In that state, the old result must survive both the abort and the start write that came before it. To set this up, the stimulus first lets one conversion finish and leaves the done flag set. It then issues a new start with the done-clear bit held at 1, waits twenty ticks, and pulses `low_power` for a single clock. Start requests made during a conversion are exercised through both the register and the pin, and a stray restart would show up afterwards as a busy flag that returns to 1.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W = 10;
  localparam int HI_W  = 8;
  localparam int LO_W  = RES_W - HI_W;
  localparam int POS_W = $clog2(RES_W);

  // control byte bit positions (software decodes these)
  localparam int B_EXT  = 5;
  localparam int B_DONE = 4;
  localparam int B_GO   = 3;
  localparam int CH_W   = 3;

  // one successive-approximation step on the tested bit
  function automatic logic [RES_W-1:0] trial_next(input logic [RES_W-1:0] word,
                                                  input logic [POS_W-1:0] pos,
                                                  input logic gt);
    logic [RES_W-1:0] w;
    w = word;
    if (!gt) w[pos] = 1'b0;
    if (pos != '0) w[pos - 1'b1] = 1'b1;
    return w;
  endfunction

  // true when tick count 'cnt' closes a bit trial
  function automatic bit trial_end(input int cnt, input int lead, input int per, input int nbits);
    return (cnt >= lead + per) && (cnt <= lead + per * nbits) && (((cnt - lead) % per) == 0);
  endfunction

  // bit index tested in the trial that ends at 'cnt'
  function automatic int trial_bit(input int cnt, input int lead, input int per, input int nbits);
    return nbits - (cnt - lead) / per;
  endfunction
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic pin,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              lvl_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin};
    end
  endgenerate

  // level seen at the previous machine-cycle boundary
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    lvl_q <= 1'b1;
    else if (tick) lvl_q <= chain[STAGES-1];

  assign rise_o = tick & en & chain[STAGES-1] & ~lvl_q;
endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
  import sar_pkg::*;
#(
  parameter int INIT_CYC = 2,
  parameter int SAMP_CYC = 8,
  parameter int BIT_CYC  = 4,
  parameter int NBITS    = RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic             abort,
  output logic             run_o,
  output logic             busy_evt_o,
  output logic             trial_evt_o,
  output logic [POS_W-1:0] trial_pos_o,
  output logic             fin_evt_o
);
  localparam int LEAD  = INIT_CYC + SAMP_CYC;
  localparam int TOTAL = LEAD + BIT_CYC * NBITS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             run_tick;

  assign cnt_n    = cnt_q + 1'b1;
  assign run_tick = run_q & tick & ~abort;

  assign busy_evt_o  = run_tick & (int'(cnt_n) == 1);
  assign trial_evt_o = run_tick & trial_end(int'(cnt_n), LEAD, BIT_CYC, NBITS);
  assign trial_pos_o = POS_W'(trial_bit(int'(cnt_n), LEAD, BIT_CYC, NBITS));
  assign fin_evt_o   = run_tick & (int'(cnt_n) == TOTAL);
  assign run_o       = run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort || fin_evt_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_tick) begin
      cnt_q <= cnt_n;
    end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort,
  input  logic             trial_evt,
  input  logic [POS_W-1:0] trial_pos,
  input  logic             fin_evt,
  input  logic             cmp_gt,
  output logic [RES_W-1:0] word_o,
  output logic [RES_W-1:0] next_o
);
  logic [RES_W-1:0] word_q;

  assign next_o = trial_next(word_q, trial_pos, cmp_gt);
  assign word_o = word_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              word_q <= '0;
    else if (abort)          word_q <= '0;
    else if (go)             word_q <= RES_W'(1) << (RES_W - 1);
    else if (fin_evt)        word_q <= '0;
    else if (trial_evt)      word_q <= next_o;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int INIT_CYC    = 2,
  parameter int SAMP_CYC    = 8,
  parameter int BIT_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             low_power,
  input  logic             ctrl_wr,
  input  logic [5:0]       ctrl_wdata,
  output logic [7:0]       ctrl_rd,
  output logic [HI_W-1:0]  high_rd,
  input  logic             ext_start,
  input  logic             cmp_gt,
  output logic [RES_W-1:0] dac_word,
  output logic [CH_W-1:0]  mux_sel,
  output logic             done_flag
);
  logic             ext_en_q, done_q, cmd_q, busy_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] res_q;

  // named internal events
  logic             ext_rise, go_evt, run_q, busy_evt, trial_evt, fin_evt;
  logic [POS_W-1:0] trial_pos;
  logic [RES_W-1:0] trial_word, trial_nxt;
  logic             sw_go_wr;

  assign go_evt   = mc_tick & ~run_q & ~low_power & (cmd_q | ext_rise);
  assign sw_go_wr = ctrl_wr & ctrl_wdata[B_GO] & ~run_q & ~low_power;

  sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .en(ext_en_q),
    .pin(ext_start), .rise_o(ext_rise)
  );

  sar_phase_timer #(
    .INIT_CYC(INIT_CYC), .SAMP_CYC(SAMP_CYC), .BIT_CYC(BIT_CYC), .NBITS(RES_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .go(go_evt), .abort(low_power),
    .run_o(run_q), .busy_evt_o(busy_evt), .trial_evt_o(trial_evt),
    .trial_pos_o(trial_pos), .fin_evt_o(fin_evt)
  );

  sar_trial_reg u_trial (
    .clk(clk), .rst_n(rst_n), .go(go_evt), .abort(low_power),
    .trial_evt(trial_evt), .trial_pos(trial_pos), .fin_evt(fin_evt),
    .cmp_gt(cmp_gt), .word_o(trial_word), .next_o(trial_nxt)
  );

  // plain configuration fields
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_en_q <= 1'b0;
      chan_q   <= '0;
    end else if (ctrl_wr) begin
      ext_en_q <= ctrl_wdata[B_EXT];
      chan_q   <= ctrl_wdata[CH_W-1:0];
    end

  // command flip-flop: set by write or external edge, self-clearing
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cmd_q <= 1'b0;
    else if (low_power || fin_evt) cmd_q <= 1'b0;
    else if (go_evt || sw_go_wr)  cmd_q <= 1'b1;

  // readable busy status
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    busy_q <= 1'b0;
    else if (low_power || fin_evt) busy_q <= 1'b0;
    else if (busy_evt)             busy_q <= 1'b1;

  // done flag: completion wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              done_q <= 1'b0;
    else if (fin_evt)                        done_q <= 1'b1;
    else if (ctrl_wr && !ctrl_wdata[B_DONE]) done_q <= 1'b0;

  // result only moves on completion
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       res_q <= '0;
    else if (fin_evt) res_q <= trial_nxt;

  assign ctrl_rd   = {res_q[LO_W-1:0], ext_en_q, done_q, busy_q, chan_q};
  assign high_rd   = res_q[RES_W-1:LO_W];
  assign dac_word  = trial_word;
  assign mux_sel   = chan_q;
  assign done_flag = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             low_power,
  input logic             go_evt,
  input logic             fin_evt,
  input logic             run_q,
  input logic             busy_q,
  input logic             cmd_q,
  input logic             ext_en_q,
  input logic             done_flag,
  input logic [RES_W-1:0] res_q,
  input logic [RES_W-1:0] dac_word
);
  // R1: with external enable off, only the command can launch
  p_ext_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en_q && !cmd_q) |-> !go_evt);

  // R5: first trial word is the MSB alone
  p_first_trial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> (dac_word == (RES_W'(1) << (RES_W - 1))));

  // R4: busy never shows outside a conversion
  p_busy_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> run_q);

  // R7: completion raises done and drops busy
  p_done_on_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (done_flag && !busy_q));

  // R9: a running conversion is not restarted
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !go_evt);

  // R10: abort stops the run and parks the DAC
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> (!run_q && !busy_q && dac_word == '0));

  // R10: stored result only changes at completion
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> $stable(res_q));
endmodule

bind sar_seq sar_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .low_power(low_power), .go_evt(go_evt),
  .fin_evt(fin_evt), .run_q(run_q), .busy_q(busy_q), .cmd_q(cmd_q),
  .ext_en_q(ext_en_q), .done_flag(done_flag), .res_q(res_q), .dac_word(dac_word)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic       low_power = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rd, high_rd;
  logic       ext_start = 1'b0;
  logic       cmp_gt;
  logic [9:0] dac_word;
  logic [2:0] mux_sel;
  logic       done_flag;
  int         vin = 0;
  int         tdiv = 0;
  int         n_cmp = 0, n_bad = 0;
  bit         ended = 0;
  logic [9:0] exp_q[$];

  always #10 clk = ~clk;

  // comparator model of the analog side
  assign cmp_gt = (vin > int'(dac_word));

  // machine-cycle pulse every 4 clocks
  always @(negedge clk) begin
    tdiv    <= (tdiv + 1) % 4;
    mc_tick <= (tdiv == 3);
  end

  sar_seq dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .low_power(low_power),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd), .high_rd(high_rd),
    .ext_start(ext_start), .cmp_gt(cmp_gt), .dac_word(dac_word),
    .mux_sel(mux_sel), .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic tick_wait(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!mc_tick) @(posedge clk);
    end
    #2;
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  // {ext_en, done_keep, start, chan}
  function automatic logic [5:0] cw(input bit ext, input bit keep, input bit go, input logic [2:0] ch);
    return {ext, keep, go, ch};
  endfunction

  // bench's own view of the converged code: largest code strictly below v
  function automatic logic [9:0] model(input int v);
    return (v == 0) ? 10'd0 : 10'(v - 1);
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge done_flag);
      #2;
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected completion", 1, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(high_rd == e[9:2], "R7", "high result", high_rd, e[9:2]);
        check(ctrl_rd[7:6] == e[1:0], "R6", "low result bits", ctrl_rd[7:6], e[1:0]);
      end
    end
  end

  // software-started conversion driver
  task automatic conv_sw(input int v, input bit detail, input bit poke);
    vin = v;
    wr(cw(0, 0, 0, 3'd5));                 // clear done (R11)
    check(done_flag == 0, "R11", "done clear", done_flag, 0);
    tick_wait(1);
    exp_q.push_back(model(v));
    wr(cw(0, 0, 1, 3'd5));
    #2;
    if (detail) check(ctrl_rd[3] == 0, "R4", "busy after write", ctrl_rd[3], 0);
    for (int k = 1; k <= 51; k++) begin
      tick_wait(1);
      if (detail) begin
        if (k == 1) begin
          check(ctrl_rd[3] == 0, "R4", "busy tick1", ctrl_rd[3], 0);
          check(dac_word == 10'h200, "R5", "first trial", dac_word, 10'h200);
        end
        if (k == 2)  check(ctrl_rd[3] == 1, "R4", "busy tick2", ctrl_rd[3], 1);
        if (k == 14) check(dac_word == 10'h200, "R5", "trial held", dac_word, 10'h200);
        if (k == 15) check(dac_word == ((v > 10'h200) ? 10'h300 : 10'h100),
                           "R6", "second trial", dac_word, (v > 10'h200) ? 10'h300 : 10'h100);
        if (k == 50) check(done_flag == 0, "R3", "not done at 50", done_flag, 0);
      end
      if (poke && k == 20) wr(cw(0, 0, 1, 3'd5));
    end
    check(done_flag == 1, "R3", "done at 51", done_flag, 1);
    check(ctrl_rd[3] == 0, "R4", "busy after done", ctrl_rd[3], 0);
    check(dac_word == 0, "R5", "dac idle", dac_word, 0);
    if (poke) begin
      tick_wait(5);
      check(ctrl_rd[3] == 0, "R9", "no restart after sw poke", ctrl_rd[3], 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(ctrl_rd == 8'h00, "R4", "reset ctrl", ctrl_rd, 0);
    check(high_rd == 8'h00, "R7", "reset high", high_rd, 0);
    check(dac_word == 0, "R5", "reset dac", dac_word, 0);
    rst_n = 1'b1;
    tick_wait(1);

    // R8 channel select
    wr(cw(0, 0, 0, 3'd5));
    #2;
    check(mux_sel == 3'd5, "R8", "mux select", mux_sel, 5);

    // R3..R7 software conversions
    conv_sw(10'h3FF, 1, 0);
    conv_sw(10'h000, 1, 0);
    conv_sw(10'h155, 0, 0);
    conv_sw(10'h001, 0, 0);
    conv_sw(10'h200, 0, 1);                // R9 software poke mid-run

    // R1: external edge ignored when disabled
    wr(cw(0, 0, 0, 3'd2));
    ext_start = 1'b0;
    tick_wait(2);
    @(negedge clk) ext_start = 1'b1;
    tick_wait(3);
    check(ctrl_rd[3] == 0, "R1", "ext disabled busy", ctrl_rd[3], 0);
    check(done_flag == 0, "R1", "ext disabled done", done_flag, 0);

    // R2: external start enabled, with R9 external poke
    vin = 10'h155;
    wr(cw(1, 0, 0, 3'd2));
    @(negedge clk) ext_start = 1'b0;
    tick_wait(2);
    exp_q.push_back(model(vin));
    @(negedge clk) ext_start = 1'b1;
    for (int k = 1; k <= 51; k++) begin
      tick_wait(1);
      if (k == 2)  check(ctrl_rd[3] == 1, "R2", "ext busy", ctrl_rd[3], 1);
      if (k == 20) ext_start = 1'b0;
      if (k == 23) ext_start = 1'b1;
    end
    check(done_flag == 1, "R2", "ext done at 51", done_flag, 1);
    tick_wait(5);
    check(ctrl_rd[3] == 0, "R9", "no restart after ext poke", ctrl_rd[3], 0);

    // R10: abort keeps the earlier result and done
    wr(cw(0, 1, 1, 3'd2));
    tick_wait(20);
    @(negedge clk) low_power = 1'b1;
    @(negedge clk) low_power = 1'b0;
    #2;
    check(ctrl_rd[3] == 0, "R10", "busy after abort", ctrl_rd[3], 0);
    check(dac_word == 0, "R10", "dac after abort", dac_word, 0);
    check(done_flag == 1, "R10", "done kept", done_flag, 1);
    check(high_rd == 8'h55, "R10", "high kept", high_rd, 8'h55);
    check(ctrl_rd[7:6] == 2'b00, "R10", "low kept", ctrl_rd[7:6], 0);
    tick_wait(60);
    check(ctrl_rd[3] == 0, "R10", "no resume", ctrl_rd[3], 0);
    check(high_rd == 8'h55, "R10", "high still kept", high_rd, 8'h55);
    @(negedge clk) low_power = 1'b1;
    wr(cw(0, 1, 1, 3'd2));
    tick_wait(3);
    check(ctrl_rd[3] == 0, "R10", "start dropped in low power", ctrl_rd[3], 0);
    @(negedge clk) low_power = 1'b0;
    tick_wait(3);
    check(ctrl_rd[3] == 0, "R10", "no late start", ctrl_rd[3], 0);

    // R11: done clear semantics
    wr(cw(0, 0, 0, 3'd2));
    #2;
    check(done_flag == 0, "R11", "write 0 clears", done_flag, 0);
    wr(cw(0, 1, 0, 3'd2));
    #2;
    check(ctrl_rd[4] == 0, "R11", "write 1 no set", ctrl_rd[4], 0);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    finish_run();
  end
endmodule